// File: doc/BRIEF.md
# Bit-Sliced Four-Bit ALU with Condition Flags

This block computes a four-bit result from two operands using a ripple chain of identical one-bit slices. A four-bit control word steers every slice at once. One bit complements operand A in every slice. One bit complements operand B in every slice and also feeds the carry into the lowest slice, which turns addition into subtraction. A two-bit select then picks AND, OR or add. Beside the result, the block raises sign, carry, zero and signed-overflow flags. It also raises a signed less-than flag and an equality flag, and both are meant to be read while the block subtracts.

The arithmetic core has no state. A thin registered wrapper captures all outputs on the rising clock edge, so a bench can sample them one cycle after it drives the inputs. A user who needs a comparison sets the control word to subtract and reads `lt_o` or `eq_o`. A user who needs plain arithmetic reads `result_o` and the four basic flags.

Top module: `bitslice_alu`

## Requirements
- R1: Control word layout is `ctrl_i[3]` = invert A, `ctrl_i[2]` = negate B, `ctrl_i[1:0]` = operation. Operation 00 gives the AND of the effective operands, 01 gives their OR, 10 gives their sum, and 11 gives zero. The effective A is A complemented when invert A is 1. The effective B is B complemented when negate B is 1.
- R2: The sum is effective A plus effective B plus a carry-in equal to negate B, taken mod 16. Control 0010 therefore gives A+B, and control 0110 gives A−B.
- R3: `ovf_o` is 1 exactly when the signed sum of the effective operands plus the carry-in falls outside −8..7. It follows the adder chain for every operation.
- R4: `carry_o` is bit 4 of the unsigned sum of the effective operands plus the carry-in.
- R5: `sign_o` equals bit 3 of the result.
- R6: `zero_o` is 1 exactly when all four result bits are 0.
- R7: `lt_o` equals sign XOR overflow. Under control 0110 it is 1 exactly when signed A < signed B. This includes A=0111, B=1000, which gives 0, and A=1000, B=0111, which gives 1.
- R8: `eq_o` is 1 exactly when the control word is 0110 and A equals B. It is 0 for every other control word.
- R9: Outputs are registered on the rising edge of `clk_i` and show the inputs present at that edge. An active-low asynchronous `rst_ni` drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| ctrl_i | input | 4 | Invert A, negate B, 2-bit operation |
| result_o | output | 4 | Registered result |
| sign_o | output | 1 | Result MSB |
| carry_o | output | 1 | Carry out of the top slice |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow |
| lt_o | output | 1 | Signed A < B (valid when subtracting) |
| eq_o | output | 1 | A equals B while subtracting |

## Verification
The bench runs all sixteen control words against all 256 operand pairs. Every output is compared with an integer model, and the pairs that straddle the signed boundary get their own named checks. A less-than flag built from the raw sign bit would fail on 7 versus −8 and on −8 versus 7. An overflow flag taken from the wrong carries would misreport sums near −8 and 7. A missing carry-in on negate B would shift every difference by one. An equality flag that ignores the control word would assert during additions that happen to yield zero.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W = 4;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_ADD  = 2'b10,
    OP_NONE = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    inv_a;
    logic    neg_b;
    alu_op_e op;
  } alu_ctrl_t;

  localparam alu_ctrl_t CTRL_SUB = '{inv_a: 1'b0, neg_b: 1'b1, op: OP_ADD};
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    inv_a_i,
  input  logic    neg_b_i,
  input  alu_op_e op_i,
  input  logic    cin_i,
  output logic    res_o,
  output logic    cout_o
);
  logic a_eff, b_eff, prop, sum;

  assign a_eff  = a_i ^ inv_a_i;
  assign b_eff  = b_i ^ neg_b_i;
  assign prop   = a_eff ^ b_eff;
  assign sum    = prop ^ cin_i;
  assign cout_o = (a_eff & b_eff) | (cin_i & prop);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_eff & b_eff;
      OP_OR:   res_o = a_eff | b_eff;
      OP_ADD:  res_o = sum;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_ctrl_t        ctrl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_msb_in_o,
  output logic             c_out_o
);
  logic [WIDTH:0] carry;

  // negate B doubles as the +1 of two's-complement negation
  assign carry[0] = ctrl_i.neg_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .inv_a_i (ctrl_i.inv_a),
      .neg_b_i (ctrl_i.neg_b),
      .op_i    (ctrl_i.op),
      .cin_i   (carry[i]),
      .res_o   (res_o[i]),
      .cout_o  (carry[i+1])
    );
  end

  assign c_msb_in_o = carry[WIDTH-1];
  assign c_out_o    = carry[WIDTH];
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             c_msb_in_i,
  input  logic             c_out_i,
  input  alu_ctrl_t        ctrl_i,
  output logic             sign_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             lt_o,
  output logic             eq_o
);
  assign sign_o  = res_i[WIDTH-1];
  assign carry_o = c_out_i;
  assign zero_o  = ~|res_i;
  assign ovf_o   = c_msb_in_i ^ c_out_i;
  // overflow flips the sign of A-B, so undo it
  assign lt_o    = sign_o ^ ovf_o;
  assign eq_o    = zero_o & (ctrl_i == CTRL_SUB);
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             sign_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             lt_o,
  output logic             eq_o
);
  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] res_c;
  logic             c_msb_in, c_out;
  logic             sign_c, carry_c, zero_c, ovf_c, lt_c, eq_c;
  logic             vld_q;

  assign ctrl = alu_ctrl_t'(ctrl_i);

  alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i        (a_i),
    .b_i        (b_i),
    .ctrl_i     (ctrl),
    .res_o      (res_c),
    .c_msb_in_o (c_msb_in),
    .c_out_o    (c_out)
  );

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i      (res_c),
    .c_msb_in_i (c_msb_in),
    .c_out_i    (c_out),
    .ctrl_i     (ctrl),
    .sign_o     (sign_c),
    .carry_o    (carry_c),
    .zero_o     (zero_c),
    .ovf_o      (ovf_c),
    .lt_o       (lt_c),
    .eq_o       (eq_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      sign_o   <= 1'b0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      ovf_o    <= 1'b0;
      lt_o     <= 1'b0;
      eq_o     <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      result_o <= res_c;
      sign_o   <= sign_c;
      carry_o  <= carry_c;
      zero_o   <= zero_c;
      ovf_o    <= ovf_c;
      lt_o     <= lt_c;
      eq_o     <= eq_c;
      vld_q    <= 1'b1;
    end
  end

  p_sign_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> sign_o == result_o[WIDTH-1]);

  p_zero_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> zero_o == (result_o == '0));

  p_sub_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(ctrl_i) == 4'b0110) |-> result_o == WIDTH'($past(a_i) - $past(b_i)));

  p_lt_signed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(ctrl_i) == 4'b0110) |-> lt_o == ($signed($past(a_i)) < $signed($past(b_i))));

  p_eq_sub_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(ctrl_i) == 4'b0110) |-> eq_o == ($past(a_i) == $past(b_i)));

  p_eq_other_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(ctrl_i) != 4'b0110) |-> !eq_o);

  p_ovf_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(ctrl_i) == 4'b0010) |->
      ovf_o == (($past(a_i[WIDTH-1]) == $past(b_i[WIDTH-1])) &&
                (result_o[WIDTH-1] != $past(a_i[WIDTH-1]))));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $past(ctrl_i) == 4'b0110 && $past(a_i[WIDTH-1]) == $past(b_i[WIDTH-1])) |-> !ovf_o);
endmodule

// File: tb/bitslice_alu_tb_top.sv
module bitslice_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a = '0, b = '0, ctrl = '0;
  logic [3:0] result;
  logic       sign, carry, zero, ovf, lt, eq;
  int         n_run = 0, n_fail = 0, cyc = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bitslice_alu dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .a_i      (a),
    .b_i      (b),
    .ctrl_i   (ctrl),
    .result_o (result),
    .sign_o   (sign),
    .carry_o  (carry),
    .zero_o   (zero),
    .ovf_o    (ovf),
    .lt_o     (lt),
    .eq_o     (eq)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s ctrl=%b a=%b b=%b actual=%0d expected=%0d",
               req, what, ctrl, a, b, act, exp);
    end
  endtask

  // drive at negedge, output registered at next posedge, sample at following negedge
  task automatic run_vec(input int c, input int av, input int bv);
    int ea, eb, cin, s, sa, sb, ss, er, ec, eo, esg, ez, elt, eeq;
    @(negedge clk);
    ctrl = 4'(c); a = 4'(av); b = 4'(bv);
    @(negedge clk);
    ea  = c[3] ? (~av & 15) : av;
    eb  = c[2] ? (~bv & 15) : bv;
    cin = c[2];
    s   = ea + eb + cin;
    sa  = (ea > 7) ? ea - 16 : ea;
    sb  = (eb > 7) ? eb - 16 : eb;
    ss  = sa + sb + cin;
    case (c & 3)
      0: er = ea & eb;
      1: er = ea | eb;
      2: er = s & 15;
      default: er = 0;
    endcase
    ec  = (s >> 4) & 1;
    eo  = (ss < -8 || ss > 7) ? 1 : 0;
    esg = (er >> 3) & 1;
    ez  = (er == 0) ? 1 : 0;
    elt = esg ^ eo;
    eeq = (c == 6 && av == bv) ? 1 : 0;
    chk("R1", "result", int'(result), er);
    chk("R4", "carry", int'(carry), ec);
    chk("R3", "ovf", int'(ovf), eo);
    chk("R5", "sign", int'(sign), esg);
    chk("R6", "zero", int'(zero), ez);
    chk("R7", "lt", int'(lt), elt);
    chk("R8", "eq", int'(eq), eeq);
    if (c == 6) begin
      int sav, sbv;
      sav = (av > 7) ? av - 16 : av;
      sbv = (bv > 7) ? bv - 16 : bv;
      chk("R2", "difference", int'(result), (av - bv) & 15);
      chk("R7", "signed_lt", int'(lt), (sav < sbv) ? 1 : 0);
    end
    if (c == 2) chk("R2", "sum", int'(result), (av + bv) & 15);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_run++; n_fail++;
        $display("FAIL R9 watchdog actual=%0d expected=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    ctrl = 4'b0010; a = 4'd3; b = 4'd5;
    repeat (3) @(negedge clk);
    // R9: reset holds every output at 0
    chk("R9", "reset_result", int'(result), 0);
    chk("R9", "reset_zero", int'(zero), 0);
    chk("R9", "reset_flags", int'({sign, carry, ovf, lt, eq}), 0);
    rst_n = 1'b1;
    // R9: one-cycle latency, value appears after the next rising edge
    @(negedge clk);
    ctrl = 4'b0010; a = 4'd6; b = 4'd1;
    @(posedge clk);
    #1 chk("R9", "latency", int'(result), 7);
    // R7 boundary pairs for the signed comparison
    run_vec(6, 7, 8);
    chk("R7", "lt_7_vs_m8", int'(lt), 0);
    run_vec(6, 8, 7);
    chk("R7", "lt_m8_vs_7", int'(lt), 1);
    // R3 overflow on 7+1
    run_vec(2, 7, 1);
    chk("R3", "ovf_7p1", int'(ovf), 1);
    // R8 addition giving zero must not flag equality
    run_vec(2, 8, 8);
    chk("R8", "eq_on_add", int'(eq), 0);
    // full sweep
    for (int c = 0; c < 16; c++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run_vec(c, x, y);
    // R9: asynchronous reset clears outputs without a clock edge
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R9", "async_reset", int'(result), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule